// File: doc/BRIEF.md
# Slave-Mode Serial Audio Port

This block connects a stereo codec to on-chip processing logic over a synchronous four-wire serial link. The codec is the timing master: it drives the bit clock and a one-bit-wide frame sync pulse. The port follows the codec's timing. Each frame carries four 16-bit words. Slot 0 is left audio and slot 1 is right audio. Slots 2 and 3 carry control words outbound and status words inbound.

All serial pins are brought into the system clock domain through a two-stage synchronizer, and edges of the bit clock are detected there. The port shifts received words in on falling bit-clock edges. It left-aligns the two audio words into 24-bit samples and presents them as a pair. A one-cycle frame-done strobe marks the moment the pair is updated. On the transmit side, software-facing logic loads a left/right sample pair and two control words. The port snapshots them at the start of each frame and shifts them out on rising edges.

Two sticky flags report missed deadlines: a transmit underrun and a receive overrun. A status acknowledge clears both flags.

Top module: `sap_port`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `sdout_o`, `rx_left_o`, `rx_right_o`, `frame_done_o`, `tx_underrun_o` and `rx_overrun_o` are all zero.
- R2: A received 16-bit word is assembled most significant bit first. It appears in the 24-bit sample with its bit 15 at bit 23 and bits 7..0 of the sample zero.
- R3: Slot 0 of a frame feeds `rx_left_o` and slot 1 feeds `rx_right_o`. The contents of slots 2 and 3 never reach either output.
- R4: Each frame transmits, most significant bit first, `tx_left_i[23:8]`, `tx_right_i[23:8]`, `tx_ctrl0_i`, then `tx_ctrl1_i`. One bit is sent per bit period, changing after the rising bit-clock edge. Bits 7..0 of the sample inputs are not sent.
- R5: A frame starts when `fsync_i` is seen high at a falling bit-clock edge. The next falling edge samples the MSB of slot 0. Received data is sampled on falling edges only.
- R6: `frame_done_o` is high for exactly one system clock per complete frame, after the slot 1 word has been captured.
- R7: A frame sync pulse that arrives in the middle of a frame restarts both slot pointers at slot 0. A truncated frame produces no `frame_done_o`.
- R8: If slot 0 begins transmitting while no `tx_wr_i` has occurred since the previous slot 0 load, `tx_underrun_o` is set and the previously loaded words are sent again.
- R9: If slot 1 is captured while the previous pair has not been acknowledged by `rx_rd_i`, `rx_overrun_o` is set in the same cycle as `frame_done_o`.
- R10: Both flags stay set until `status_clr_i`. One cycle after `status_clr_i`, both flags read zero.
- R11: `rx_left_o` and `rx_right_o` change only in a cycle where `frame_done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Bit clock from the codec |
| fsync_i | input | 1 | Frame sync pulse from the codec |
| sdin_i | input | 1 | Serial data from the codec |
| sdout_o | output | 1 | Serial data to the codec |
| tx_wr_i | input | 1 | Loads the four transmit words |
| tx_left_i | input | 24 | Left transmit sample (upper 16 bits sent) |
| tx_right_i | input | 24 | Right transmit sample (upper 16 bits sent) |
| tx_ctrl0_i | input | 16 | Control word for slot 2 |
| tx_ctrl1_i | input | 16 | Control word for slot 3 |
| rx_rd_i | input | 1 | Acknowledges the current received pair |
| rx_left_o | output | 24 | Left received sample, left-aligned |
| rx_right_o | output | 24 | Right received sample, left-aligned |
| frame_done_o | output | 1 | One-cycle strobe when a new pair is presented |
| status_clr_i | input | 1 | Clears both error flags |
| tx_underrun_o | output | 1 | Sticky transmit underrun flag |
| rx_overrun_o | output | 1 | Sticky receive overrun flag |

## Verification
The assertions assume that the bit clock is far slower than the system clock, so that each bit-clock level lasts several system cycles. They also assume that the frame sync and data inputs change only near rising bit-clock edges, which keeps them stable when the synchronized falling edge samples them.

The bench generates the bit clock with six system cycles per half period. It changes `fsync_i` and `sdin_i` only together with the rising level, and reads `sdout_o` just before the falling level, well after the synchronizer and output register have settled. Host-side strobes are single-cycle pulses issued between frames.

// File: rtl/sap_pkg.sv
package sap_pkg;

    localparam int WORD_W     = 16;
    localparam int SAMPLE_W   = 24;
    localparam int NUM_SLOTS  = 4;
    localparam int SYNC_DEPTH = 2;

    localparam int PAD_W  = SAMPLE_W - WORD_W;
    localparam int BIT_W  = $clog2(WORD_W);
    localparam int SLOT_W = $clog2(NUM_SLOTS);

    // The four words carried in one outbound frame, in slot order.
    typedef struct packed {
        logic [WORD_W-1:0] left;
        logic [WORD_W-1:0] right;
        logic [WORD_W-1:0] ctrl0;
        logic [WORD_W-1:0] ctrl1;
    } tx_frame_t;

    typedef struct packed {
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
    } stereo_t;

    function automatic logic [SAMPLE_W-1:0] align_word(input logic [WORD_W-1:0] w);
        return {w, {PAD_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] pick_slot(input tx_frame_t f,
                                                    input logic [SLOT_W-1:0] s);
        logic [WORD_W-1:0] r;
        case (s)
            SLOT_W'(0): r = f.left;
            SLOT_W'(1): r = f.right;
            SLOT_W'(2): r = f.ctrl0;
            default:    r = f.ctrl1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sap_sync.sv
module sap_sync
    import sap_pkg::*;
#(
    parameter int STAGES = SYNC_DEPTH
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_i,
    input  logic fsync_i,
    input  logic sdin_i,
    output logic fs_s,
    output logic din_s,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sclk_p, fs_p, din_p;
    logic              sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_p <= '0;
            fs_p   <= '0;
            din_p  <= '0;
            sclk_d <= 1'b0;
        end else begin
            sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
            fs_p   <= {fs_p[STAGES-2:0], fsync_i};
            din_p  <= {din_p[STAGES-2:0], sdin_i};
            sclk_d <= sclk_p[STAGES-1];
        end
    end

    assign fs_s  = fs_p[STAGES-1];
    assign din_s = din_p[STAGES-1];
    assign rise  =  sclk_p[STAGES-1] & ~sclk_d;
    assign fall  = ~sclk_p[STAGES-1] &  sclk_d;

endmodule

// File: rtl/sap_rx.sv
module sap_rx
    import sap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    fall,
    input  logic    fs_s,
    input  logic    din_s,
    input  logic    rd,
    input  logic    clr,
    output stereo_t pair,
    output logic    done,
    output logic    overrun
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic                armed;
    logic [BIT_W-1:0]    bit_cnt;
    logic [SLOT_W-1:0]   slot;
    logic [WORD_W-2:0]   shreg;
    logic [WORD_W-1:0]   left_hold;
    logic                unread;
    logic [WORD_W-1:0]   word_now;

    assign word_now = {shreg, din_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            bit_cnt   <= '0;
            slot      <= '0;
            shreg     <= '0;
            left_hold <= '0;
            unread    <= 1'b0;
            pair      <= '0;
            done      <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rd) unread <= 1'b0;
            if (fall && fs_s) begin
                armed   <= 1'b1;
                bit_cnt <= '0;
                slot    <= '0;
            end else if (fall && armed) begin
                shreg <= word_now[WORD_W-2:0];
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= '0;
                    if (slot == SLOT_W'(0)) left_hold <= word_now;
                    if (slot == SLOT_W'(1)) begin
                        pair.left  <= align_word(left_hold);
                        pair.right <= align_word(word_now);
                        done       <= 1'b1;
                        unread     <= 1'b1;
                        if (unread && !rd) overrun <= 1'b1;
                    end
                    if (slot == LAST_SLOT) begin
                        slot  <= '0;
                        armed <= 1'b0;
                    end else begin
                        slot <= slot + SLOT_W'(1);
                    end
                end else begin
                    bit_cnt <= bit_cnt + BIT_W'(1);
                end
            end
            if (clr) overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/sap_tx.sv
module sap_tx
    import sap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                rise,
    input  logic                fall,
    input  logic                fs_s,
    input  logic                wr,
    input  logic [SAMPLE_W-1:0] left_i,
    input  logic [SAMPLE_W-1:0] right_i,
    input  logic [WORD_W-1:0]   ctrl0_i,
    input  logic [WORD_W-1:0]   ctrl1_i,
    input  logic                clr,
    output logic                sdout,
    output logic                underrun
);
    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    tx_frame_t          stage, cur, src;
    logic               fresh;
    logic               armed;
    logic [BIT_W-1:0]   bit_cnt;
    logic [SLOT_W-1:0]  slot;
    logic               load_now;
    logic [WORD_W-1:0]  word_sel;

    wire unused_low = ^{left_i[PAD_W-1:0], right_i[PAD_W-1:0]};

    assign load_now = (bit_cnt == '0) && (slot == '0);

    always_comb begin
        src      = load_now ? stage : cur;
        word_sel = pick_slot(src, slot);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage    <= '0;
            cur      <= '0;
            fresh    <= 1'b0;
            armed    <= 1'b0;
            bit_cnt  <= '0;
            slot     <= '0;
            sdout    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            if (fall && fs_s) begin
                armed   <= 1'b1;
                bit_cnt <= '0;
                slot    <= '0;
            end else if (rise && armed) begin
                if (load_now) begin
                    cur   <= stage;
                    fresh <= 1'b0;
                    if (!fresh) underrun <= 1'b1;
                end
                sdout <= word_sel[LAST_BIT - bit_cnt];
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= '0;
                    if (slot == LAST_SLOT) begin
                        slot  <= '0;
                        armed <= 1'b0;
                    end else begin
                        slot <= slot + SLOT_W'(1);
                    end
                end else begin
                    bit_cnt <= bit_cnt + BIT_W'(1);
                end
            end else if (rise) begin
                sdout <= 1'b0;
            end
            if (wr) begin
                stage.left  <= left_i[SAMPLE_W-1 -: WORD_W];
                stage.right <= right_i[SAMPLE_W-1 -: WORD_W];
                stage.ctrl0 <= ctrl0_i;
                stage.ctrl1 <= ctrl1_i;
                fresh       <= 1'b1;
            end
            if (clr) underrun <= 1'b0;
        end
    end

endmodule

// File: rtl/sap_port.sv
module sap_port
    import sap_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                sclk_i,
    input  logic                fsync_i,
    input  logic                sdin_i,
    output logic                sdout_o,
    input  logic                tx_wr_i,
    input  logic [SAMPLE_W-1:0] tx_left_i,
    input  logic [SAMPLE_W-1:0] tx_right_i,
    input  logic [WORD_W-1:0]   tx_ctrl0_i,
    input  logic [WORD_W-1:0]   tx_ctrl1_i,
    input  logic                rx_rd_i,
    output logic [SAMPLE_W-1:0] rx_left_o,
    output logic [SAMPLE_W-1:0] rx_right_o,
    output logic                frame_done_o,
    input  logic                status_clr_i,
    output logic                tx_underrun_o,
    output logic                rx_overrun_o
);
    logic    fs_s, din_s, rise, fall;
    stereo_t pair;

    sap_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sclk_i  (sclk_i),
        .fsync_i (fsync_i),
        .sdin_i  (sdin_i),
        .fs_s    (fs_s),
        .din_s   (din_s),
        .rise    (rise),
        .fall    (fall)
    );

    sap_rx u_rx (
        .clk     (clk),
        .rst     (rst),
        .fall    (fall),
        .fs_s    (fs_s),
        .din_s   (din_s),
        .rd      (rx_rd_i),
        .clr     (status_clr_i),
        .pair    (pair),
        .done    (frame_done_o),
        .overrun (rx_overrun_o)
    );

    sap_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .rise     (rise),
        .fall     (fall),
        .fs_s     (fs_s),
        .wr       (tx_wr_i),
        .left_i   (tx_left_i),
        .right_i  (tx_right_i),
        .ctrl0_i  (tx_ctrl0_i),
        .ctrl1_i  (tx_ctrl1_i),
        .clr      (status_clr_i),
        .sdout    (sdout_o),
        .underrun (tx_underrun_o)
    );

    assign rx_left_o  = pair.left;
    assign rx_right_o = pair.right;

endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk
    import sap_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                sclk_i,
    input logic                fsync_i,
    input logic                sdin_i,
    input logic                sdout_o,
    input logic                tx_wr_i,
    input logic [SAMPLE_W-1:0] tx_left_i,
    input logic [SAMPLE_W-1:0] tx_right_i,
    input logic [WORD_W-1:0]   tx_ctrl0_i,
    input logic [WORD_W-1:0]   tx_ctrl1_i,
    input logic                rx_rd_i,
    input logic [SAMPLE_W-1:0] rx_left_o,
    input logic [SAMPLE_W-1:0] rx_right_o,
    input logic                frame_done_o,
    input logic                status_clr_i,
    input logic                tx_underrun_o,
    input logic                rx_overrun_o
);
    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        frame_done_o |=> !frame_done_o);

    assert_overrun_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_overrun_o) |-> frame_done_o);

    assert_underrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_underrun_o && !status_clr_i) |=> tx_underrun_o);

    assert_overrun_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        (rx_overrun_o && !status_clr_i) |=> rx_overrun_o);

    assert_clear_flags_R10: assert property (@(posedge clk) disable iff (rst)
        status_clr_i |=> (!tx_underrun_o && !rx_overrun_o));

    assert_pair_stable_R11: assert property (@(posedge clk) disable iff (rst)
        !frame_done_o |-> ($stable(rx_left_o) && $stable(rx_right_o)));

    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (rx_left_o[PAD_W-1:0] == '0) && (rx_right_o[PAD_W-1:0] == '0));

endmodule

bind sap_port sap_port_chk u_chk (.*);

// File: tb/sap_port_test.sv
`timescale 1ns/1ps
module sap_port_test;

    localparam int HALF = 6;
    localparam int NV   = 5;

    // Each vector: {rx slot0..3 (64 bits), tx left, right, ctrl0, ctrl1 (64 bits)}
    localparam logic [127:0] VEC [NV] = '{
        {64'h1234_ABCD_0F0F_F0F0, 64'hCAFE_BEEF_0300_0000},
        {64'h8000_0001_FFFF_0000, 64'h0001_8000_5555_AAAA},
        {64'hFFFF_FFFF_1111_2222, 64'h7FFE_0000_FFFF_0001},
        {64'h0000_0000_DEAD_BEEF, 64'hA5A5_5A5A_0000_FFFF},
        {64'h5A5A_C3C3_0000_0000, 64'h0F00_00F0_1234_5678}
    };

    logic        clk = 0, rst = 1;
    logic        sclk_i = 0, fsync_i = 0, sdin_i = 0;
    logic        sdout_o;
    logic        tx_wr_i = 0, rx_rd_i = 0, status_clr_i = 0;
    logic [23:0] tx_left_i = 0, tx_right_i = 0;
    logic [15:0] tx_ctrl0_i = 0, tx_ctrl1_i = 0;
    logic [23:0] rx_left_o, rx_right_o;
    logic        frame_done_o, tx_underrun_o, rx_overrun_o;

    int checks = 0, errors = 0, fd_count = 0;

    always #5 clk = ~clk;

    sap_port uut (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .fsync_i(fsync_i), .sdin_i(sdin_i),
        .sdout_o(sdout_o), .tx_wr_i(tx_wr_i), .tx_left_i(tx_left_i),
        .tx_right_i(tx_right_i), .tx_ctrl0_i(tx_ctrl0_i), .tx_ctrl1_i(tx_ctrl1_i),
        .rx_rd_i(rx_rd_i), .rx_left_o(rx_left_o), .rx_right_o(rx_right_o),
        .frame_done_o(frame_done_o), .status_clr_i(status_clr_i),
        .tx_underrun_o(tx_underrun_o), .rx_overrun_o(rx_overrun_o)
    );

    always @(posedge clk) if (!rst && frame_done_o) fd_count <= fd_count + 1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse(ref logic sig);
        tick(1);
        sig = 1;
        tick(1);
        sig = 0;
    endtask

    task automatic drive_bit(input logic f, input logic d, output logic s);
        tick(1);
        sclk_i = 1; fsync_i = f; sdin_i = d;
        tick(HALF - 1);
        s = sdout_o;
        tick(1);
        sclk_i = 0;
        tick(HALF - 1);
    endtask

    task automatic load_tx(input logic [63:0] t);
        tx_left_i  = {t[63:48], 8'hA5};
        tx_right_i = {t[47:32], 8'h3C};
        tx_ctrl0_i = t[31:16];
        tx_ctrl1_i = t[15:0];
        pulse(tx_wr_i);
    endtask

    task automatic send_frame(input logic [63:0] rxw, output logic [63:0] txb);
        logic s;
        drive_bit(1'b1, 1'b0, s);
        for (int i = 63; i >= 0; i--) begin
            drive_bit(1'b0, rxw[i], s);
            txb[i] = s;
        end
        drive_bit(1'b0, 1'b0, s);
        drive_bit(1'b0, 1'b0, s);
        tick(4);
    endtask

    task automatic send_partial(input int nbits);
        logic s;
        drive_bit(1'b1, 1'b0, s);
        for (int i = 0; i < nbits; i++) drive_bit(1'b0, i[0], s);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] txb;
        int          fd0;
        logic [63:0] last_tx;

        tick(5);
        check("R1 reset outputs", {rx_left_o, rx_right_o, sdout_o, frame_done_o,
              tx_underrun_o, rx_overrun_o}, 64'h0);
        rst = 0;
        tick(1);
        check("R1 after reset", {rx_left_o, rx_right_o, sdout_o, frame_done_o,
              tx_underrun_o, rx_overrun_o}, 64'h0);

        // Table-driven frames
        for (int v = 0; v < NV; v++) begin
            load_tx(VEC[v][63:0]);
            fd0 = fd_count;
            send_frame(VEC[v][127:64], txb);
            check("R2 R5 left sample", {40'h0, rx_left_o}, {40'h0, VEC[v][127:112], 8'h00});
            check("R3 right sample slot1", {40'h0, rx_right_o}, {40'h0, VEC[v][111:96], 8'h00});
            check("R4 transmit bits", txb, VEC[v][63:0]);
            check("R6 one strobe per frame", 64'(fd_count - fd0), 64'd1);
            check("R8 R9 flags clear", {62'h0, tx_underrun_o, rx_overrun_o}, 64'h0);
            pulse(rx_rd_i);
        end
        last_tx = VEC[NV-1][63:0];

        // Underrun: no transmit load before the frame
        send_frame(64'h1357_2468_0000_0000, txb);
        check("R8 underrun set", {63'h0, tx_underrun_o}, 64'h1);
        check("R8 repeats old words", txb, last_tx);
        check("R9 no overrun after read", {63'h0, rx_overrun_o}, 64'h0);

        // Overrun: previous pair left unread
        load_tx(64'h1111_2222_3333_4444);
        send_frame(64'h9ABC_DEF0_0000_0000, txb);
        check("R9 overrun set", {63'h0, rx_overrun_o}, 64'h1);
        check("R10 underrun still set", {63'h0, tx_underrun_o}, 64'h1);
        check("R3 new pair", {16'h0, rx_left_o, rx_right_o}, {16'h0, 16'h9ABC, 8'h0, 16'hDEF0, 8'h0});

        // Clear and ignored strobes
        pulse(status_clr_i);
        tick(1);
        check("R10 flags cleared", {62'h0, tx_underrun_o, rx_overrun_o}, 64'h0);
        pulse(rx_rd_i);
        tick(3);
        check("R11 pair held without frame", {16'h0, rx_left_o, rx_right_o},
              {16'h0, 16'h9ABC, 8'h0, 16'hDEF0, 8'h0});

        // Pointer recovery: truncated frame then a full one
        load_tx(64'hFACE_0B0E_C001_D00D);
        fd0 = fd_count;
        send_partial(20);
        check("R7 no strobe for truncated frame", 64'(fd_count - fd0), 64'd0);
        send_frame(64'h2468_ACE0_7777_8888, txb);
        check("R7 resync left", {40'h0, rx_left_o}, {40'h0, 16'h2468, 8'h00});
        check("R7 resync right", {40'h0, rx_right_o}, {40'h0, 16'hACE0, 8'h00});
        check("R7 resync strobe", 64'(fd_count - fd0), 64'd1);
        check("R7 transmit restarts at slot0", txb, 64'hFACE_0B0E_C001_D00D);

        finish_run();
    end

endmodule